// File: doc/BRIEF.md
# Tagged Address Translation Cache

This block is a small, fully associative cache of recent page translations. It sits between an address generator and memory. A requester presents a virtual address together with the identifier of the address space that is currently running. The block splits the address into a page number (upper bits) and a byte offset (lower bits). It compares the page number and the identifier against every stored entry in parallel.

When one valid entry agrees on both, the response in the next cycle carries the stored frame number with the offset appended unchanged. When no entry agrees, the response reports a miss and no translation. The surrounding logic then fetches the frame from the in-memory page table and writes it back through the fill port. Software-visible maintenance is limited to two operations: clearing every entry, or clearing only the entries that belong to one address space.

Top module: `tlb_xlate`

## Requirements
- R1: A hit returns a physical address whose upper bits are the stored frame number and whose low OFF_W bits equal the request's low OFF_W bits.
- R2: An entry hits only if it is valid, its page number equals request bits [VPN_W+OFF_W-1:OFF_W], and its stored identifier equals the request identifier. The same page number under another identifier misses.
- R3: The response appears one clock after the request. `rsp_valid` follows `req_valid`, exactly one of `rsp_hit`/`rsp_miss` is high with it, and the physical address is zero on a miss.
- R4: A fill is written into the lowest-index invalid entry while one exists, and no valid entry is overwritten in that case.
- R5: When every entry is valid, a fill replaces the entry named by a rotating pointer. The pointer starts at index 0 after reset and advances by one, wrapping, after each such replacing fill.
- R6: `flush_all` invalidates every entry in one cycle.
- R7: `flush_asid_en` invalidates only the entries whose identifier equals `flush_asid`, and leaves the others able to hit.
- R8: A lookup in the same cycle as a fill or flush is answered from the contents held before that cycle.
- R9: A fill in the same cycle as a flush leaves the newly written entry valid, while the flush removes the old entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| req_asid | input | ASID_W | Identifier of the requesting address space |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | Translation not cached |
| rsp_paddr | output | PFN_W+OFF_W | Translated address, zero on miss |
| fill_valid | input | 1 | Write a new entry |
| fill_vpn | input | VPN_W | Page number of the new entry |
| fill_asid | input | ASID_W | Identifier of the new entry |
| fill_pfn | input | PFN_W | Frame number of the new entry |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate entries of one identifier |
| flush_asid | input | ASID_W | Identifier to invalidate |

## Verification
A lookup and a fill of the very page being looked up can land in the same cycle. The bench raises both strobes at one falling edge. It then expects a miss for that request, because the lookup sees the old contents, and a hit on the next request. A flush and a fill can also coincide. The bench asserts both together and judges the result by lookups afterwards: the old entries must miss and the fresh entry must hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_VPN_W   = 20;
  localparam int unsigned DEF_OFF_W   = 12;
  localparam int unsigned DEF_ASID_W  = 8;
  localparam int unsigned DEF_PFN_W   = 20;
endpackage

// File: rtl/tlb_match.sv
// Parallel tag compare over all entries; lowest matching index wins.
module tlb_match #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_tab,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  output logic                           any_hit,
  output logic [IDX_W-1:0]               hit_idx
);
  logic [ENTRIES-1:0] line_hit;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign line_hit[g] = valid[g] && (vpn_tab[g] == key_vpn) &&
                         (asid_tab[g] == key_asid);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (line_hit[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit = |line_hit;
endmodule

// File: rtl/tlb_victim.sv
// Picks the slot for a fill: lowest free slot, else a rotating pointer.
module tlb_victim #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid,
  input  logic               fill,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             all_full;

  assign all_full = &valid;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim = all_full ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill && all_full) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
      else                             rr_q <= rr_q + 1'b1;
    end
  end

  // R4: while a free slot exists the chosen slot is a free one
  a_r4_fill_free_slot: assert property (@(posedge clk) disable iff (rst)
    (fill && !all_full) |-> !valid[victim]);

  // R5: a replacing fill moves the pointer by exactly one step
  a_r5_rr_step: assert property (@(posedge clk) disable iff (rst)
    (fill && all_full && rr_q != IDX_W'(ENTRIES - 1)) |=> (rr_q == $past(rr_q) + 1'b1));
endmodule

// File: rtl/tlb_valid_next.sv
// Next-state of the valid vector: flushes first, then the fill sets its slot.
module tlb_valid_next #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ASID_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_tab,
  input  logic                           flush_all,
  input  logic                           flush_sel,
  input  logic [ASID_W-1:0]              flush_id,
  input  logic                           fill,
  input  logic [IDX_W-1:0]               fill_idx,
  output logic [ENTRIES-1:0]             valid_nxt
);
  logic [ENTRIES-1:0] kill;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
    assign kill[g] = flush_all || (flush_sel && (asid_tab[g] == flush_id));
  end

  always_comb begin
    valid_nxt = valid & ~kill;
    if (fill) valid_nxt[fill_idx] = 1'b1;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned VPN_W   = DEF_VPN_W,
  parameter int unsigned OFF_W   = DEF_OFF_W,
  parameter int unsigned ASID_W  = DEF_ASID_W,
  parameter int unsigned PFN_W   = DEF_PFN_W,
  localparam int unsigned VA_W   = VPN_W + OFF_W,
  localparam int unsigned PA_W   = PFN_W + OFF_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [PA_W-1:0]   rsp_paddr,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  // Entry storage: tags and frames carry no reset, only the valid bits do.
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0]             valid_d;

  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  logic             look_hit;
  logic [IDX_W-1:0] look_idx;
  logic [IDX_W-1:0] fill_idx;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .valid    (valid_q),
    .vpn_tab  (vpn_q),
    .asid_tab (asid_q),
    .key_vpn  (req_vpn),
    .key_asid (req_asid),
    .any_hit  (look_hit),
    .hit_idx  (look_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk    (clk),
    .rst    (rst),
    .valid  (valid_q),
    .fill   (fill_valid),
    .victim (fill_idx)
  );

  tlb_valid_next #(.ENTRIES(ENTRIES), .ASID_W(ASID_W)) u_vnext (
    .valid     (valid_q),
    .asid_tab  (asid_q),
    .flush_all (flush_all),
    .flush_sel (flush_asid_en),
    .flush_id  (flush_asid),
    .fill      (fill_valid),
    .fill_idx  (fill_idx),
    .valid_nxt (valid_d)
  );

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      vpn_q[fill_idx]  <= fill_vpn;
      asid_q[fill_idx] <= fill_asid;
      pfn_q[fill_idx]  <= fill_pfn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_d;
  end

  // Registered response built from pre-update contents.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && look_hit;
      rsp_miss  <= req_valid && !look_hit;
      rsp_paddr <= (req_valid && look_hit) ? {pfn_q[look_idx], req_off} : '0;
    end
  end

  // R3: response strobe tracks the request one cycle later
  a_r3_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r3_rsp_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss);
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss}));
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_paddr == '0));
  // R1: offset passes through untouched
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_hit -> (rsp_paddr[OFF_W-1:0] == $past(req_off))));
  // R6: a flush with no fill leaves nothing valid
  a_r6_flush_empty: assert property (@(posedge clk) disable iff (rst)
    (flush_all && !fill_valid) |=> (valid_q == '0));
  // R9: a fill survives a simultaneous flush
  a_r9_fill_survives: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && flush_all) |=> ($countones(valid_q) == 1));
endmodule

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_asid = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_pfn = '0;
  logic        flush_all = 1'b0;
  logic        flush_asid_en = 1'b0;
  logic [7:0]  flush_asid = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_asid(req_asid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
  );

  // fill table: {vpn, asid, pfn}
  localparam logic [47:0] FILLS [8] = '{
    {20'h00010, 8'h11, 20'hA0000},
    {20'h00011, 8'h11, 20'hA0001},
    {20'h00012, 8'h33, 20'hA0002},
    {20'h00010, 8'h22, 20'hB0003},
    {20'hFFFFF, 8'h11, 20'hA0004},
    {20'h12345, 8'h33, 20'hC0005},
    {20'h00000, 8'h22, 20'h00006},
    {20'h54321, 8'h11, 20'hFFFFF}
  };

  // lookup vectors: {vaddr, asid, expect_hit, expect_paddr}
  localparam logic [72:0] LOOKS [11] = '{
    {32'h00010ABC, 8'h11, 1'b1, 32'hA0000ABC},
    {32'h00010ABC, 8'h22, 1'b1, 32'hB0003ABC},
    {32'h00010ABC, 8'h33, 1'b0, 32'h0},
    {32'h00011000, 8'h11, 1'b1, 32'hA0001000},
    {32'h00011FFF, 8'h22, 1'b0, 32'h0},
    {32'hFFFFF123, 8'h11, 1'b1, 32'hA0004123},
    {32'h12345FFF, 8'h33, 1'b1, 32'hC0005FFF},
    {32'h00000000, 8'h22, 1'b1, 32'h00006000},
    {32'h54321777, 8'h11, 1'b1, 32'hFFFFF777},
    {32'h00013000, 8'h11, 1'b0, 32'h0},
    {32'h00012456, 8'h33, 1'b1, 32'hA0002456}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] a, input bit eh,
                        input logic [31:0] ep, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_asid = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_hit == eh && rsp_miss == !eh && rsp_paddr == ep, req,
          {29'b0, rsp_valid, rsp_hit, rsp_miss, rsp_paddr},
          {29'b0, 1'b1, eh, !eh, ep});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state: idle response
    check(!rsp_valid && !rsp_hit && !rsp_miss && rsp_paddr == 0, "R3 reset",
          {rsp_valid, rsp_hit, rsp_miss}, 0);
    // empty cache misses
    lookup(32'h00010ABC, 8'h11, 1'b0, 32'h0, "R3 empty miss");

    // R4: eight fills into an empty cache, none overwriting another
    for (int i = 0; i < 8; i++) do_fill(FILLS[i][47:28], FILLS[i][27:20], FILLS[i][19:0]);
    // table walk covering R1 and R2
    for (int i = 0; i < 11; i++)
      lookup(LOOKS[i][72:41], LOOKS[i][40:33], LOOKS[i][32], LOOKS[i][31:0], "R1/R2 table");
    lookup(32'h54321000, 8'h11, 1'b1, 32'hFFFFF000, "R4 all eight kept");

    // R5: full cache, pointer at 0 then 1
    do_fill(20'h0AAAA, 8'h44, 20'h11111);
    lookup(32'h00010ABC, 8'h11, 1'b0, 32'h0, "R5 entry0 evicted");
    lookup(32'h00011ABC, 8'h11, 1'b1, 32'hA0001ABC, "R5 entry1 kept");
    lookup(32'h0AAAA005, 8'h44, 1'b1, 32'h11111005, "R5 new entry");
    do_fill(20'h0BBBB, 8'h44, 20'h22222);
    lookup(32'h00011ABC, 8'h11, 1'b0, 32'h0, "R5 entry1 evicted");
    lookup(32'h00012ABC, 8'h33, 1'b1, 32'hA0002ABC, "R5 entry2 kept");

    // R7: flush identifier 0x33 (entries 2 and 5)
    @(negedge clk);
    flush_asid_en = 1'b1; flush_asid = 8'h33;
    @(negedge clk);
    flush_asid_en = 1'b0;
    lookup(32'h00012000, 8'h33, 1'b0, 32'h0, "R7 flushed id");
    lookup(32'h12345000, 8'h33, 1'b0, 32'h0, "R7 flushed id");
    lookup(32'h00010000, 8'h22, 1'b1, 32'hB0003000, "R7 other id kept");
    lookup(32'h0BBBB000, 8'h44, 1'b1, 32'h22222000, "R7 other id kept");

    // R4: refill the holes, then the pointer (at 2) evicts the first refill
    do_fill(20'h0CCCC, 8'h55, 20'h33333);
    do_fill(20'h0DDDD, 8'h55, 20'h44444);
    lookup(32'h0AAAA000, 8'h44, 1'b1, 32'h11111000, "R4 holes used, entry kept");
    lookup(32'hFFFFF000, 8'h11, 1'b1, 32'hA0004000, "R4 holes used, entry kept");
    lookup(32'h0DDDD001, 8'h55, 1'b1, 32'h44444001, "R4 refill present");
    do_fill(20'h0EEEE, 8'h66, 20'h55555);
    lookup(32'h0CCCC000, 8'h55, 1'b0, 32'h0, "R4 first refill sat in slot 2");
    lookup(32'h0DDDD000, 8'h55, 1'b1, 32'h44444000, "R4 second refill kept");

    // R8: lookup and fill of same page together
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    lookup(32'h0EEEE000, 8'h66, 1'b0, 32'h0, "R6 flush all");
    lookup(32'h00000000, 8'h22, 1'b0, 32'h0, "R6 flush all");
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h07777123; req_asid = 8'h77;
    fill_valid = 1'b1; fill_vpn = 20'h07777; fill_asid = 8'h77; fill_pfn = 20'h66666;
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    check(rsp_miss && !rsp_hit, "R8 same-cycle fill", {rsp_hit, rsp_miss}, 2'b01);
    lookup(32'h07777123, 8'h77, 1'b1, 32'h66666123, "R8 fill visible next");
    // R8: lookup with flush in same cycle sees old contents
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h07777456; req_asid = 8'h77;
    flush_asid_en = 1'b1; flush_asid = 8'h77;
    @(negedge clk);
    req_valid = 1'b0; flush_asid_en = 1'b0;
    check(rsp_hit && rsp_paddr == 32'h66666456, "R8 same-cycle flush",
          {rsp_hit, rsp_paddr}, {1'b1, 32'h66666456});
    lookup(32'h07777456, 8'h77, 1'b0, 32'h0, "R8 flush visible next");

    // R9: fill and flush together
    do_fill(20'h01111, 8'h01, 20'h0F0F0);
    @(negedge clk);
    flush_all = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h02222; fill_asid = 8'h02; fill_pfn = 20'h0E0E0;
    @(negedge clk);
    flush_all = 1'b0; fill_valid = 1'b0;
    lookup(32'h01111000, 8'h01, 1'b0, 32'h0, "R9 old entry gone");
    lookup(32'h02222ABC, 8'h02, 1'b1, 32'h0E0E0ABC, "R9 new entry kept");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule